// File: doc/BRIEF.md
# Flash command and abort controller

This block is the command interpreter that sits in front of a flash array. It watches single-cycle bus writes for a two-write unlock prefix followed by a command byte. From these it moves the array between these modes: plain read, identifier/protection read, word programming, whole-array erase, sector erase, error, and a timed recovery. An abstract array model reports the end of each operation and any failure on two strobes. The block drives the mode, an error flag and a busy indication back to the bus side.

Two things can stop work in progress: the reset command byte F0h, and a hardware abort pulse. The reset command has no effect on a programming or whole-array erase. It does abort a sector erase, and it clears an error. The hardware abort stops anything. Whenever a running operation or an error is left this way, the array passes through a recovery phase. That phase lasts a fixed number of clock cycles, computed as clock frequency in MHz times the recovery time in microseconds. Busy stays high for the whole phase.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: An unlock prefix is data AAh at address 555h followed by data 55h at address AAAh. A third write of A0h to 555h arms programming, and the next write starts it (mode 2). A third write of 90h to 555h enters identifier read (mode 1). A third write of 80h to 555h arms erase; a following write of 10h starts whole-array erase (mode 3) and 30h starts sector erase (mode 4).
- R2: Any write that does not continue the sequence returns the decoder to its idle step and leaves the mode unchanged. A later write then needs a fresh prefix.
- R3: The reset command is data F0h to any address, with or without a prefix. In read mode it changes nothing. In identifier read (mode 1) it returns to read mode (mode 0) one clock after the write.
- R4: The reset command has no effect while programming (mode 2) or whole-array erase (mode 3) runs.
- R5: The reset command during sector erase puts the block in recovery (mode 6). After exactly REC_CYCLES clocks in recovery the mode becomes read (mode 0).
- R6: A failure strobe during mode 2, 3 or 4 enters error (mode 5) with the error flag set. A reset command in error clears the flag and enters recovery, which ends in read mode as in R5.
- R7: A hardware abort in mode 2, 3, 4, 5 or 6 clears the error flag and (re)starts recovery. In mode 0 or 1 it returns directly to mode 0.
- R8: A done strobe during mode 2, 3 or 4 returns to mode 0.
- R9: Busy is high exactly in modes 2, 3, 4 and 6. Writes other than the reset command are ignored outside read mode. All writes are ignored in recovery.
- R10: After the synchronous reset the mode is 0 and both the error flag and busy are low.
- R11: REC_CYCLES equals CLK_MHZ times RECOVER_US.

Mode encoding: 0 read, 1 identifier read, 2 programming, 3 whole-array erase, 4 sector erase, 5 error, 6 recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| hw_abort | input | 1 | Hardware abort pulse |
| op_done | input | 1 | Array reports the current operation finished |
| op_fail | input | 1 | Array reports the current operation failed |
| mode | output | 3 | Current array mode (encoding above) |
| err_flag | output | 1 | Failure flag, set in error mode |
| busy | output | 1 | Array not available for reads |

## Verification
A decoder stuck in a wrong step shows up on the very next write. That write either starts an operation it should not, or fails to start one, so mode differs one clock later. A recovery counter that loads or ends one count off moves the fall of busy and the return to mode 0 by a cycle, and this is visible when the exit cycle is sampled. A mode register that accepts the reset command in the wrong state leaves programming or erase early, or stays in error, on the clock after the write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    M_READ    = 3'd0,
    M_IDREAD  = 3'd1,
    M_PROGRAM = 3'd2,
    M_BULK    = 3'd3,
    M_SECTOR  = 3'd4,
    M_ERROR   = 3'd5,
    M_RECOVER = 3'd6
  } mode_e;

  typedef enum logic [2:0] {
    C_NONE,
    C_RESET,
    C_PROGRAM,
    C_BULK,
    C_SECTOR,
    C_IDREAD
  } cmd_e;

  typedef enum logic [2:0] {
    D_IDLE,
    D_KEY1,
    D_KEY2,
    D_PGM_ARMED,
    D_ERS_ARMED
  } dec_e;

  localparam logic [7:0] KEY1_DATA   = 8'hAA;
  localparam logic [7:0] KEY2_DATA   = 8'h55;
  localparam logic [7:0] OP_RESET    = 8'hF0;
  localparam logic [7:0] OP_PROGRAM  = 8'hA0;
  localparam logic [7:0] OP_ERASE    = 8'h80;
  localparam logic [7:0] OP_IDREAD   = 8'h90;
  localparam logic [7:0] OP_BULK     = 8'h10;
  localparam logic [7:0] OP_SECTOR   = 8'h30;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 'h555,
  parameter logic [ADDR_W-1:0] KEY2_ADDR = 'hAAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output cmd_e              cmd
);

  dec_e step_q, step_d;

  always_comb begin
    step_d = step_q;
    cmd    = C_NONE;
    if (wr_en) begin
      step_d = D_IDLE;
      if (wr_data == OP_RESET) begin
        cmd = C_RESET;
      end else if (accept) begin
        unique case (step_q)
          D_IDLE:
            if (wr_addr == KEY1_ADDR && wr_data == KEY1_DATA) step_d = D_KEY1;
          D_KEY1:
            if (wr_addr == KEY2_ADDR && wr_data == KEY2_DATA) step_d = D_KEY2;
          D_KEY2:
            if (wr_addr == KEY1_ADDR) begin
              if (wr_data == OP_PROGRAM)     step_d = D_PGM_ARMED;
              else if (wr_data == OP_ERASE)  step_d = D_ERS_ARMED;
              else if (wr_data == OP_IDREAD) cmd = C_IDREAD;
            end
          D_PGM_ARMED: cmd = C_PROGRAM;
          D_ERS_ARMED:
            if (wr_data == OP_BULK)        cmd = C_BULK;
            else if (wr_data == OP_SECTOR) cmd = C_SECTOR;
          default: step_d = D_IDLE;
        endcase
      end
    end
    if (flush || !accept) step_d = D_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= D_IDLE;
    else     step_q <= step_d;
  end

endmodule

// File: rtl/flash_cmd_recover.sv
module flash_cmd_recover #(
  parameter int REC_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);

  localparam int CNT_W = (REC_CYCLES < 2) ? 1 : $clog2(REC_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start)         cnt_q <= CNT_W'(REC_CYCLES - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int CLK_MHZ    = 250,
  parameter int RECOVER_US = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              hw_abort,
  input  logic              op_done,
  input  logic              op_fail,
  output logic [2:0]        mode,
  output logic              err_flag,
  output logic              busy
);

  localparam int REC_CYCLES = CLK_MHZ * RECOVER_US;

  mode_e mode_q, mode_d;
  logic  err_q, err_d, busy_q, rec_start, rec_expired;
  cmd_e  cmd;

  flash_cmd_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk     (clk),
    .rst     (rst),
    .accept  (mode_q == M_READ),
    .flush   (hw_abort),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  flash_cmd_recover #(.REC_CYCLES(REC_CYCLES)) u_recover (
    .clk     (clk),
    .rst     (rst),
    .start   (rec_start),
    .expired (rec_expired)
  );

  always_comb begin
    mode_d    = mode_q;
    err_d     = err_q;
    rec_start = 1'b0;
    if (hw_abort) begin
      err_d = 1'b0;
      if (mode_q == M_READ || mode_q == M_IDREAD) begin
        mode_d = M_READ;
      end else begin
        mode_d    = M_RECOVER;
        rec_start = 1'b1;
      end
    end else begin
      unique case (mode_q)
        M_READ:
          unique case (cmd)
            C_PROGRAM: mode_d = M_PROGRAM;
            C_BULK:    mode_d = M_BULK;
            C_SECTOR:  mode_d = M_SECTOR;
            C_IDREAD:  mode_d = M_IDREAD;
            default:   mode_d = M_READ;
          endcase
        M_IDREAD:
          if (cmd == C_RESET) mode_d = M_READ;
        M_PROGRAM, M_BULK, M_SECTOR:
          if (op_fail) begin
            mode_d = M_ERROR;
            err_d  = 1'b1;
          end else if (op_done) begin
            mode_d = M_READ;
          end else if (mode_q == M_SECTOR && cmd == C_RESET) begin
            mode_d    = M_RECOVER;
            rec_start = 1'b1;
          end
        M_ERROR:
          if (cmd == C_RESET) begin
            mode_d    = M_RECOVER;
            err_d     = 1'b0;
            rec_start = 1'b1;
          end
        M_RECOVER:
          if (rec_expired) mode_d = M_READ;
        default: mode_d = M_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_READ;
      err_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      err_q  <= err_d;
      busy_q <= (mode_d == M_PROGRAM) || (mode_d == M_BULK) ||
                (mode_d == M_SECTOR)  || (mode_d == M_RECOVER);
    end
  end

  assign mode     = mode_q;
  assign err_flag = err_q;
  assign busy     = busy_q;

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int ADDR_W     = 12,
  parameter int REC_CYCLES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              hw_abort,
  input logic              op_done,
  input logic              op_fail,
  input logic [2:0]        mode,
  input logic              err_flag,
  input logic              busy
);

  localparam int RUN_W = $clog2(REC_CYCLES + 2);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || hw_abort || mode != 3'd6) run_q <= '0;
    else if (run_q != {RUN_W{1'b1}})   run_q <= run_q + 1'b1;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (mode == 3'd0 && !err_flag && !busy)); // R10

  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (rst)
    busy == (mode == 3'd2 || mode == 3'd3 || mode == 3'd4 || mode == 3'd6)); // R9

  AST_ERR_IN_ERROR: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> mode == 3'd5); // R6

  AST_PROG_KEEPS: assert property (@(posedge clk) disable iff (rst)
    ((mode == 3'd2 || mode == 3'd3) && wr_en && wr_data == 8'hF0 &&
     !hw_abort && !op_done && !op_fail) |=> $stable(mode)); // R4

  AST_ABORT_RUNNING: assert property (@(posedge clk) disable iff (rst)
    (hw_abort && mode >= 3'd2) |=> (mode == 3'd6 && !err_flag)); // R7

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (hw_abort && mode <= 3'd1) |=> mode == 3'd0); // R7

  AST_DONE_READ: assert property (@(posedge clk) disable iff (rst)
    ((mode == 3'd2 || mode == 3'd3 || mode == 3'd4) && op_done &&
     !op_fail && !hw_abort) |=> mode == 3'd0); // R8

  AST_RECOVER_BOUND: assert property (@(posedge clk) disable iff (rst)
    mode == 3'd6 |-> run_q < RUN_W'(REC_CYCLES)); // R5

  AST_RECOVER_LEN: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 && $past(mode) == 3'd6) |-> run_q == RUN_W'(REC_CYCLES)); // R5

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(
  .ADDR_W(ADDR_W), .REC_CYCLES(REC_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .hw_abort(hw_abort), .op_done(op_done), .op_fail(op_fail),
  .mode(mode), .err_flag(err_flag), .busy(busy)
);

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;

  localparam int AW      = 12;
  localparam int MHZ     = 4;
  localparam int US      = 2;
  localparam int REC_EXP = 8;   // R11: 4 MHz * 2 us

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          hw_abort = 1'b0;
  logic          op_done = 1'b0;
  logic          op_fail = 1'b0;
  logic [2:0]    mode;
  logic          err_flag;
  logic          busy;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .CLK_MHZ(MHZ), .RECOVER_US(US)) i_flash_cmd_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hw_abort(hw_abort), .op_done(op_done), .op_fail(op_fail),
    .mode(mode), .err_flag(err_flag), .busy(busy)
  );

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int busy_of(int m);
    return (m == 2 || m == 3 || m == 4 || m == 6) ? 1 : 0;
  endfunction

  task automatic chk_state(string req, int exp_mode, int exp_err);
    chk({req, " mode"}, int'(mode), exp_mode);
    chk({req, " err"}, int'(err_flag), exp_err);
    chk({req, " busy"}, int'(busy), busy_of(exp_mode));
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr('h555, 'hAA);
    wr('hAAA, 'h55);
  endtask

  task automatic pulse_done();
    @(negedge clk); op_done = 1'b1; @(negedge clk); op_done = 1'b0;
  endtask

  task automatic pulse_fail();
    @(negedge clk); op_fail = 1'b1; @(negedge clk); op_fail = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk); hw_abort = 1'b1; @(negedge clk); hw_abort = 1'b0;
  endtask

  // called just after recovery was entered: checks the exact exit cycle
  task automatic ride_recovery(string req);
    chk_state({req, " enter"}, 6, 0);
    repeat (REC_EXP - 1) @(negedge clk);
    chk_state({req, " last"}, 6, 0);
    @(negedge clk);
    chk_state({req, " exit"}, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_state("R10 reset", 0, 0);

    // R1/R2/R3/R9: sweep every third byte after the prefix
    for (int d = 0; d < 256; d++) begin
      int exp_m;
      unlock();
      wr('h555, d);
      wr('h000, 'h00);
      exp_m = (d == 'hA0) ? 2 : (d == 'h90) ? 1 : 0;
      chk(exp_m == 2 ? "R1 program start" : exp_m == 1 ? "R1 id entry" : "R2 R3 no start",
          int'(mode), exp_m);
      if (exp_m == 2) begin
        wr('h000, 'hF0);
        chk("R4 reset ignored in program", int'(mode), 2);
        pulse_done();
        chk("R8 program done", int'(mode), 0);
      end else if (exp_m == 1) begin
        unlock(); wr('h555, 'hA0); wr('h000, 'h00);
        chk("R9 id ignores commands", int'(mode), 1);
        wr('h7FF, 'hF0);
        chk("R3 reset leaves id", int'(mode), 0);
      end
    end

    // R1/R2: sweep the byte after the erase arm
    for (int d = 0; d < 256; d++) begin
      int exp_m;
      unlock();
      wr('h555, 'h80);
      wr('h123, d);
      exp_m = (d == 'h10) ? 3 : (d == 'h30) ? 4 : 0;
      chk("R1 R2 erase select", int'(mode), exp_m);
      if (exp_m != 0) begin
        pulse_done();
        chk("R8 erase done", int'(mode), 0);
      end
    end

    // R2: broken prefix, then a would-be command
    wr('h555, 'hAA); wr('h555, 'h55); wr('h555, 'hA0); wr('h000, 'h00);
    chk_state("R2 broken prefix", 0, 0);

    // R3: reset with prefix in read mode does nothing
    unlock(); wr('h555, 'hF0);
    chk_state("R3 reset in read", 0, 0);

    // R4: reset ignored during bulk erase
    unlock(); wr('h555, 'h80); wr('h000, 'h10);
    unlock(); wr('h555, 'hF0);
    chk_state("R4 bulk keeps", 3, 0);
    pulse_done();

    // R5: reset aborts sector erase
    unlock(); wr('h555, 'h80); wr('h000, 'h30);
    wr('h456, 'hF0);
    ride_recovery("R5 sector abort");

    // R9: writes ignored during recovery
    unlock(); wr('h555, 'h80); wr('h000, 'h30);
    wr('h000, 'hF0);
    unlock(); wr('h555, 'hA0);
    repeat (REC_EXP - 5) @(negedge clk);
    chk_state("R9 recovery ignores", 0, 0);

    // R6: failure then reset command
    unlock(); wr('h555, 'hA0); wr('h010, 'h5A);
    pulse_fail();
    chk_state("R6 error entry", 5, 1);
    wr('h000, 'h00);
    chk_state("R6 error holds", 5, 1);
    wr('h000, 'hF0);
    ride_recovery("R6 error clear");

    // R7: hardware abort in programming, in error, and in id mode
    unlock(); wr('h555, 'hA0); wr('h010, 'h11);
    pulse_abort();
    ride_recovery("R7 abort program");
    unlock(); wr('h555, 'h80); wr('h000, 'h10);
    pulse_fail();
    pulse_abort();
    ride_recovery("R7 abort error");
    unlock(); wr('h555, 'h90);
    pulse_abort();
    chk_state("R7 abort id", 0, 0);

    // R7: abort during recovery restarts the full delay
    unlock(); wr('h555, 'h80); wr('h000, 'h30);
    wr('h000, 'hF0);
    repeat (3) @(negedge clk);
    pulse_abort();
    ride_recovery("R7 restart");

    // R10: reset mid-operation
    unlock(); wr('h555, 'h80); wr('h000, 'h10);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk_state("R10 reset mid-op", 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule